// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-mode state machine of a small microcontroller-style system. Software writes a set of plain configuration inputs: a low-power-run request, a deep-sleep select, a two-bit stop depth, a standby retention select and a wake-clock select. The CPU's wait-for-interrupt/event strobe then commits the selected low-power mode. From its state the block drives the regulator enables, the high-frequency clock-source enables, the SRAM bank and register retention enables, the core power-domain enable and the CPU clock gate.

The legal modes are Run, Low-power run, Sleep, Low-power sleep, three Stop depths and Standby. Low-power run requires a system clock below 2 MHz. Low-power sleep is reached only from Low-power run. When the block leaves a Stop depth, it enables only the wake oscillator chosen at entry and waits for that oscillator's ready input. When it leaves Standby, it returns to Run through a core-domain reset pulse. An illegal request is refused and sets a sticky error flag. Every Standby entry sets a sticky status flag. The block does not model regulators, oscillators or peripherals: their ready and wakeup signals are plain inputs.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, mode_o is Run (code 0). The CPU clock is enabled and the main regulator is on, with the low-power regulator off. All four hf_clk_en bits are 1, and both SRAM banks, regs_keep and core_pwr_en are 1. sysclk_sel, core_rst, stby_flag and err_flag are 0.
- R2: In Run with wfi low, lp_run_req=1 and clk_low=1 move the block to Low-power run (code 1) one cycle later. In that mode the low-power regulator is on and the main regulator is off. Dropping lp_run_req in Low-power run returns the block to Run. A wake input in Low-power run has no effect.
- R3: In Run with wfi low, lp_run_req=1 and clk_low=0 is refused. The mode stays Run and err_flag is set. err_flag holds until a cycle with flag_clr=1 and no new error.
- R4: wfi with deep_sel=0 enters Sleep (code 2) from Run, or Low-power sleep (code 3) from Low-power run. Only the CPU clock is gated and the regulator choice is unchanged. wake returns the block to the run mode it came from.
- R5: wfi with deep_sel=1 and stop_lvl 0, 1 or 2 enters Stop depth 0, 1 or 2 (codes 4, 5, 6), from Run or from Low-power run. hf_clk_en (bit0 PLL, bit1 multi-speed, bit2 16 MHz internal, bit3 32 MHz external) becomes 0 and both SRAM banks stay on. Depth 0 keeps the main regulator, while depths 1 and 2 use the low-power regulator. regs_keep is 1 for depths 0 and 1 and 0 for depth 2.
- R6: wake in a Stop depth moves the block to the wake state (code 8). In that state only the oscillator chosen by wake_sel at entry is enabled (0: bit1, 1: bit2) and the CPU clock stays gated. The block stays there until that oscillator's ready input is 1, then enters Run with sysclk_sel equal to the latched wake_sel. Changes to wake_sel after entry have no effect.
- R7: wfi with deep_sel=1 and stop_lvl=3 enters Standby (code 7) with core_pwr_en=0 and sram1_on=0. If ret_sel was 1 at entry, the low-power regulator and sram2_on stay 1. Otherwise both regulators are off and sram2_on=0. Each Standby entry sets stby_flag, which holds until a flag_clr cycle.
- R8: wake in Standby enters the reset state (code 9) with core_rst=1 for exactly RST_CYCLES cycles, then Run with sysclk_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system/power reset |
| lp_run_req | input | 1 | Request Low-power run |
| deep_sel | input | 1 | 0: sleep-type entry, 1: Stop/Standby entry |
| stop_lvl | input | 2 | 0..2 Stop depth, 3 Standby |
| ret_sel | input | 1 | Keep SRAM2 powered in Standby |
| wake_sel | input | 1 | Wake clock: 0 multi-speed, 1 16 MHz internal |
| clk_low | input | 1 | System clock is below 2 MHz |
| wfi | input | 1 | CPU wait-for-interrupt/event strobe |
| wake | input | 1 | Any enabled wakeup, interrupt or event |
| msi_rdy | input | 1 | Multi-speed oscillator ready |
| hsi_rdy | input | 1 | 16 MHz internal oscillator ready |
| flag_clr | input | 1 | Clear sticky flags |
| mode_o | output | 4 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| main_reg_on | output | 1 | Main regulator enable |
| lp_reg_on | output | 1 | Low-power regulator enable |
| hf_clk_en | output | 4 | High-frequency clock source enables |
| sram1_on | output | 1 | SRAM1 supplied |
| sram2_on | output | 1 | SRAM2 supplied |
| regs_keep | output | 1 | Full register retention |
| core_pwr_en | output | 1 | Core power domain enable |
| core_rst | output | 1 | Core-domain reset after Standby |
| sysclk_sel | output | 1 | System clock source after wake |
| stby_flag | output | 1 | Sticky: Standby was entered |
| err_flag | output | 1 | Sticky: illegal request refused |

## Verification
The bench builds the block with RST_CYCLES=3. This keeps the reset pulse after Standby short enough to count cycle by cycle. The bench sweeps every stop_lvl, every ret_sel, both wake clocks and both origin modes (Run and Low-power run). For each combination it computes the expected regulator, SRAM, retention and clock enables arithmetically from the depth. The sweep also drives the non-selected ready input and flips wake_sel while the block waits in the wake state, so the ready wait and the latched clock choice are both exercised.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_run_req,
  input  logic       deep_sel,
  input  logic [1:0] stop_lvl,
  input  logic       ret_sel,
  input  logic       wake_sel,
  input  logic       clk_low,
  input  logic       wfi,
  input  logic       wake,
  input  logic       msi_rdy,
  input  logic       hsi_rdy,
  input  logic       flag_clr,
  output logic [3:0] mode_o,
  output logic       cpu_clk_en,
  output logic       main_reg_on,
  output logic       lp_reg_on,
  output logic [3:0] hf_clk_en,
  output logic       sram1_on,
  output logic       sram2_on,
  output logic       regs_keep,
  output logic       core_pwr_en,
  output logic       core_rst,
  output logic       sysclk_sel,
  output logic       stby_flag,
  output logic       err_flag
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  typedef enum logic [3:0] {
    S_RUN = 4'd0, S_LPRUN = 4'd1, S_SLEEP = 4'd2, S_LPSLEEP = 4'd3,
    S_STOP0 = 4'd4, S_STOP1 = 4'd5, S_STOP2 = 4'd6, S_STBY = 4'd7,
    S_WAKE = 4'd8, S_CRST = 4'd9
  } st_t;

  st_t          st, nx;
  logic         ret_q, sel_q;
  logic [CW-1:0] cnt;
  logic         deep_target_ok;
  st_t          deep_target;
  logic         bad_req;
  logic         enter_stby;
  logic         sel_rdy;

  assign deep_target = st_t'({2'b01, stop_lvl});
  assign deep_target_ok = wfi && deep_sel;
  assign bad_req = (st == S_RUN) && !wfi && lp_run_req && !clk_low;
  assign enter_stby = (st == S_RUN || st == S_LPRUN) && deep_target_ok && (stop_lvl == 2'd3);
  assign sel_rdy = sel_q ? hsi_rdy : msi_rdy;

  always_comb begin
    nx = st;
    case (st)
      S_RUN: begin
        if (wfi) nx = deep_sel ? deep_target : S_SLEEP;
        else if (lp_run_req && clk_low) nx = S_LPRUN;
      end
      S_LPRUN: begin
        if (wfi) nx = deep_sel ? deep_target : S_LPSLEEP;
        else if (!lp_run_req) nx = S_RUN;
      end
      S_SLEEP:   if (wake) nx = S_RUN;
      S_LPSLEEP: if (wake) nx = S_LPRUN;
      S_STOP0, S_STOP1, S_STOP2: if (wake) nx = S_WAKE;
      S_STBY:    if (wake) nx = S_CRST;
      S_WAKE:    if (sel_rdy) nx = S_RUN;
      S_CRST:    if (cnt == CW'(RST_CYCLES - 1)) nx = S_RUN;
      default:   nx = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RUN;
      ret_q <= 1'b0;
      sel_q <= 1'b0;
      cnt <= '0;
      stby_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      st <= nx;
      if ((st == S_RUN || st == S_LPRUN) && deep_target_ok) begin
        ret_q <= ret_sel;
        if (stop_lvl != 2'd3) sel_q <= wake_sel;
      end
      if (st == S_STBY) sel_q <= 1'b0;
      if (st == S_CRST) cnt <= cnt + CW'(1);
      else cnt <= '0;
      if (enter_stby) stby_flag <= 1'b1;
      else if (flag_clr) stby_flag <= 1'b0;
      if (bad_req) err_flag <= 1'b1;
      else if (flag_clr) err_flag <= 1'b0;
    end
  end

  logic in_stop, lp_mode;
  assign in_stop = (st == S_STOP0) || (st == S_STOP1) || (st == S_STOP2);
  assign lp_mode = (st == S_LPRUN) || (st == S_LPSLEEP) || (st == S_STOP1) || (st == S_STOP2);

  assign mode_o      = st;
  assign cpu_clk_en  = (st == S_RUN) || (st == S_LPRUN);
  assign lp_reg_on   = lp_mode || ((st == S_STBY) && ret_q);
  assign main_reg_on = !lp_mode && (st != S_STBY);
  assign hf_clk_en   = (in_stop || st == S_STBY) ? 4'b0000 :
                       (st == S_WAKE) ? (sel_q ? 4'b0100 : 4'b0010) : 4'b1111;
  assign sram1_on    = (st != S_STBY);
  assign sram2_on    = (st != S_STBY) || ret_q;
  assign regs_keep   = (st != S_STOP2) && (st != S_STBY);
  assign core_pwr_en = (st != S_STBY);
  assign core_rst    = (st == S_CRST);
  assign sysclk_sel  = sel_q;

  assert_lprun_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LPRUN && $past(st) == S_RUN) |-> $past(clk_low));
  assert_lpsleep_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LPSLEEP && $past(st) != S_LPSLEEP) |-> $past(st) == S_LPRUN);
  assert_wake_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && $past(st) == S_WAKE) |-> $past(sel_q ? hsi_rdy : msi_rdy));
  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(lp_run_req && !clk_low && st == S_RUN));
  assert_stby_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stby_flag) |-> st == S_STBY);
  assert_sel_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAKE && $past(st) == S_WAKE) |-> $stable(sysclk_sel));
endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int RC = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lp_run_req = 0, deep_sel = 0, ret_sel = 0, wake_sel = 0, clk_low = 0;
  logic wfi = 0, wake = 0, msi_rdy = 0, hsi_rdy = 0, flag_clr = 0;
  logic [1:0] stop_lvl = 0;
  logic [3:0] mode_o, hf_clk_en;
  logic cpu_clk_en, main_reg_on, lp_reg_on, sram1_on, sram2_on, regs_keep;
  logic core_pwr_en, core_rst, sysclk_sel, stby_flag, err_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  pwr_mode_seq #(.RST_CYCLES(RC)) uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 regs", {main_reg_on, lp_reg_on}, 2);
    chk("R1 hf", hf_clk_en, 15);
    chk("R1 mem", {sram1_on, sram2_on, regs_keep, core_pwr_en}, 15);
    chk("R1 misc", {sysclk_sel, core_rst, stby_flag, err_flag}, 0);

    // R3 illegal low-power run
    lp_run_req = 1; clk_low = 0; tick();
    chk("R3 mode", mode_o, 0);
    chk("R3 err", err_flag, 1);
    lp_run_req = 0; tick();
    chk("R3 sticky", err_flag, 1);
    flag_clr = 1; tick(); flag_clr = 0;
    chk("R3 clear", err_flag, 0);

    // R2 legal low-power run
    lp_run_req = 1; clk_low = 1; tick();
    chk("R2 mode", mode_o, 1);
    chk("R2 regs", {main_reg_on, lp_reg_on}, 1);
    chk("R2 err", err_flag, 0);
    wake = 1; tick(); wake = 0;
    chk("R2 wake ignored", mode_o, 1);

    // R4 low-power sleep from LPRUN
    wfi = 1; deep_sel = 0; tick(); wfi = 0;
    chk("R4 lpsleep", mode_o, 3);
    chk("R4 lpsleep cpu", cpu_clk_en, 0);
    chk("R4 lpsleep reg", {main_reg_on, lp_reg_on, hf_clk_en}, 6'b011111);
    tick();
    chk("R4 lpsleep hold", mode_o, 3);
    wake = 1; tick(); wake = 0;
    chk("R4 back lprun", mode_o, 1);
    lp_run_req = 0; tick();
    chk("R2 exit", mode_o, 0);

    // R4 sleep from Run
    wfi = 1; tick(); wfi = 0;
    chk("R4 sleep", mode_o, 2);
    chk("R4 sleep cpu", cpu_clk_en, 0);
    chk("R4 sleep reg", {main_reg_on, lp_reg_on, hf_clk_en}, 6'b101111);
    wake = 1; tick(); wake = 0;
    chk("R4 back run", mode_o, 0);

    // R5..R8 sweep
    for (int lvl = 0; lvl < 4; lvl++)
      for (int ret = 0; ret < 2; ret++)
        for (int ws = 0; ws < 2; ws++)
          for (int lp = 0; lp < 2; lp++) begin
            int exp_main, exp_lp, exp_s1, exp_s2, exp_keep, exp_core;
            if (lp == 1) begin
              lp_run_req = 1; clk_low = 1; tick();
              chk("R2 sweep", mode_o, 1);
            end
            exp_main = (lvl == 0) ? 1 : 0;
            exp_lp = (lvl == 1 || lvl == 2 || (lvl == 3 && ret == 1)) ? 1 : 0;
            exp_s1 = (lvl < 3) ? 1 : 0;
            exp_s2 = (lvl < 3 || ret == 1) ? 1 : 0;
            exp_keep = (lvl < 2) ? 1 : 0;
            exp_core = (lvl < 3) ? 1 : 0;
            deep_sel = 1; stop_lvl = 2'(lvl); ret_sel = ret[0]; wake_sel = ws[0];
            wfi = 1; tick(); wfi = 0; lp_run_req = 0;
            wake_sel = ~ws[0]; ret_sel = ~ret[0];
            if (lvl < 3) begin
              chk("R5 mode", mode_o, 4 + lvl);
              chk("R5 regs", {main_reg_on, lp_reg_on}, exp_main * 2 + exp_lp);
              chk("R5 hf", hf_clk_en, 0);
              chk("R5 mem", {sram1_on, sram2_on, regs_keep, core_pwr_en},
                  exp_s1 * 8 + exp_s2 * 4 + exp_keep * 2 + exp_core);
              chk("R5 cpu", cpu_clk_en, 0);
              wake = 1; tick(); wake = 0;
              chk("R6 wake state", mode_o, 8);
              chk("R6 one osc", hf_clk_en, (ws == 1) ? 4 : 2);
              chk("R6 cpu gated", cpu_clk_en, 0);
              tick();
              chk("R6 wait", mode_o, 8);
              if (ws == 1) msi_rdy = 1; else hsi_rdy = 1;
              tick();
              chk("R6 wrong rdy", mode_o, 8);
              if (ws == 1) hsi_rdy = 1; else msi_rdy = 1;
              tick(); msi_rdy = 0; hsi_rdy = 0;
              chk("R6 run", mode_o, 0);
              chk("R6 sysclk", sysclk_sel, ws);
              chk("R6 hf", hf_clk_en, 15);
            end else begin
              chk("R7 mode", mode_o, 7);
              chk("R7 regs", {main_reg_on, lp_reg_on}, exp_lp);
              chk("R7 mem", {sram1_on, sram2_on, regs_keep, core_pwr_en}, exp_s2 * 4);
              chk("R7 hf", hf_clk_en, 0);
              chk("R7 flag", stby_flag, 1);
              flag_clr = 1; tick(); flag_clr = 0;
              chk("R7 clear", stby_flag, 0);
              wake = 1; tick(); wake = 0;
              for (int c = 0; c < RC; c++) begin
                chk("R8 reset", {mode_o, core_rst}, 9 * 2 + 1);
                tick();
              end
              chk("R8 run", mode_o, 0);
              chk("R8 rst low", core_rst, 0);
              chk("R8 sysclk", sysclk_sel, 0);
            end
            deep_sel = 0; clk_low = 0;
            tick();
          end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule